// File: doc/BRIEF.md
# ADC Conversion Sequence Status Tracker

This block follows the progress of conversion sequences inside a multi-channel analog-to-digital converter controller. A sequence begins on a start pulse, produced when software writes the control register. Each finished conversion arrives as a single-cycle done pulse. The block advances a result write pointer with every conversion and marks the conversion position that has just completed. When the last position of a sequence completes, it raises a sequence-complete flag.

Two flag-clearing policies are available, chosen by a fast-clear configuration bit. With fast-clear low, flags clear through an explicit start or a status-then-result read handshake. With fast-clear high, a result read on its own clears them. In FIFO mode the write pointer runs on across sequences instead of restarting at zero. In scan mode a new sequence begins by itself after the last conversion. The state is presented as two read-only 8-bit status words.

Top module: `adc_seq_status`

## Requirements
- R1: After reset, both status words, the write pointer and the active indicator are zero.
- R2: Conversion-complete flag n (bit n of status word 1) sets when conversion n of the current sequence completes, counting the first conversion as n = 0.
- R3: The sequence holds 4 conversions when the length bit is 0 and 8 when it is 1. The sequence-complete flag sets on the done pulse of the last position, and outside scan mode the active indicator then drops.
- R4: In scan mode the block starts the next sequence by itself after the last conversion. The sequence-complete flag is set at the end of every sequence, and outside FIFO mode the pointer returns to 0.
- R5: Outside FIFO mode a start pulse loads the write pointer with 0. Every accepted conversion moves the pointer up by one.
- R6: In FIFO mode a start pulse leaves the write pointer unchanged, and the pointer wraps from 7 to 0.
- R7: With fast-clear 0, a start pulse clears the sequence-complete flag, and result reads leave it untouched.
- R8: With fast-clear 1, any result read clears the sequence-complete flag, and a start pulse leaves it untouched.
- R9: With fast-clear 1, reading result register n clears conversion-complete flag n.
- R10: With fast-clear 0, reading result register n clears flag n only when a status read was seen while flag n was set, and no start pulse came in between. Without that status read, the result read has no effect.
- R11: A start pulse clears all conversion-complete flags. A done pulse in the same cycle as a start pulse is ignored.
- R12: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R13: Status word 0 is {sequence-complete flag in bit 7, zeros in bits 6..3, write pointer in bits 2..0}. Status word 1 holds the conversion-complete flags. Neither word changes in a cycle without a start, done or result-read event.
- R14: A done pulse that arrives while no sequence is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fast_clear | input | 1 | 1 = flags clear on result reads |
| cfg_fifo_mode | input | 1 | 1 = pointer is not reloaded at sequence start |
| cfg_scan_mode | input | 1 | 1 = sequences restart by themselves |
| cfg_long_seq | input | 1 | 0 = 4 conversions per sequence, 1 = 8 |
| seq_start | input | 1 | Start pulse from a control-register write |
| conv_done | input | 1 | One conversion has finished |
| res_rd | input | 1 | Strobe for a read of a result register |
| res_rd_idx | input | 3 | Index of the result register being read |
| stat_rd | input | 1 | Strobe for a bus read of the status words |
| status0 | output | 8 | Sequence-complete flag and write pointer |
| status1 | output | 8 | Conversion-complete flags 7..0 |
| wr_ptr | output | 3 | Result register for the conversion in progress |
| seq_active | output | 1 | A sequence is running |

## Verification
The bench builds the block with its defaults: eight result slots and a short sequence of four. With these values the 3-bit pointer can reach its wrap from 7 to 0, both in a single long sequence and across short sequences in FIFO mode. Both sequence lengths can be chosen at run time from one elaboration. Directed phases cover each clearing policy, the scan restart, and same-cycle set/clear and start/done collisions. A long stretch of random pulses and configuration changes follows, and a behavioural model is compared against every output on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Flag-clearing policy chosen by the fast-clear configuration bit.
    typedef enum logic {
        CLR_BY_HANDSHAKE = 1'b0,
        CLR_BY_RESULT    = 1'b1
    } clr_policy_e;

    // Sequence-length selection.
    typedef enum logic {
        LEN_SHORT = 1'b0,
        LEN_LONG  = 1'b1
    } seq_len_e;

    function automatic clr_policy_e to_policy(input logic fast_bit);
        return fast_bit ? CLR_BY_RESULT : CLR_BY_HANDSHAKE;
    endfunction

endpackage

// File: rtl/adc_seq_sequencer.sv
module adc_seq_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SHORT_LEN = 4,
    localparam int PTR_W = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_start,
    input  logic             conv_done,
    input  logic             scan_mode,
    input  logic             fifo_mode,
    input  logic             long_seq,
    output logic             active,
    output logic [PTR_W-1:0] ptr,
    output logic             conv_fire,
    output logic [PTR_W-1:0] conv_pos,
    output logic             seq_end
);

    localparam logic [PTR_W-1:0] LAST_LONG  = PTR_W'(NUM_SLOTS - 1);
    localparam logic [PTR_W-1:0] LAST_SHORT = PTR_W'(SHORT_LEN - 1);
    localparam logic [PTR_W-1:0] PTR_TOP    = PTR_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic             active;
        logic [PTR_W-1:0] pos;
        logic [PTR_W-1:0] ptr;
    } seq_state_t;

    seq_state_t       state_d, state_q;
    logic [PTR_W-1:0] last_pos;
    logic [PTR_W-1:0] ptr_inc;
    logic             fire;
    logic             at_end;
    seq_len_e         len_sel;

    always_comb begin
        len_sel  = seq_len_e'(long_seq);
        last_pos = (len_sel == LEN_LONG) ? LAST_LONG : LAST_SHORT;
        ptr_inc  = (state_q.ptr == PTR_TOP) ? '0 : state_q.ptr + 1'b1;
        fire     = conv_done && state_q.active && !seq_start;
        at_end   = fire && (state_q.pos == last_pos);
        state_d  = state_q;

        if (seq_start) begin
            state_d.active = 1'b1;
            state_d.pos    = '0;
            if (!fifo_mode) begin
                state_d.ptr = '0;
            end
        end else if (fire) begin
            state_d.ptr = ptr_inc;
            if (at_end) begin
                state_d.pos = '0;
                if (scan_mode) begin
                    if (!fifo_mode) begin
                        state_d.ptr = '0;
                    end
                end else begin
                    state_d.active = 1'b0;
                end
            end else begin
                state_d.pos = state_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active    = state_q.active;
    assign ptr       = state_q.ptr;
    assign conv_fire = fire;
    assign conv_pos  = state_q.pos;
    assign seq_end   = at_end;

endmodule

// File: rtl/adc_seq_ccf.sv
module adc_seq_ccf
    import adc_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int PTR_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seq_start,
    input  logic                 conv_fire,
    input  logic [PTR_W-1:0]     conv_pos,
    input  logic                 res_rd,
    input  logic [PTR_W-1:0]     res_idx,
    input  logic                 stat_rd,
    input  logic                 fast_clear,
    output logic [NUM_SLOTS-1:0] ccf
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] flag;
        logic [NUM_SLOTS-1:0] arm;
    } ccf_state_t;

    ccf_state_t           state_d, state_q;
    logic [NUM_SLOTS-1:0] set_v;
    logic [NUM_SLOTS-1:0] hit_v;
    clr_policy_e          policy;

    // Per-slot decode of the set and read-hit events.
    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        assign set_v[n] = conv_fire && (conv_pos == PTR_W'(n));
        assign hit_v[n] = res_rd && (res_idx == PTR_W'(n));
    end

    always_comb begin
        policy  = to_policy(fast_clear);
        state_d = state_q;
        for (int n = 0; n < NUM_SLOTS; n++) begin
            // arming for the handshake policy
            if (seq_start || hit_v[n]) begin
                state_d.arm[n] = 1'b0;
            end else if (stat_rd) begin
                state_d.arm[n] = state_q.flag[n];
            end
            // clear sources
            if (seq_start) begin
                state_d.flag[n] = 1'b0;
            end else if (hit_v[n]) begin
                if (policy == CLR_BY_RESULT || state_q.arm[n]) begin
                    state_d.flag[n] = 1'b0;
                end
            end
            // set overrides any clear
            if (set_v[n]) begin
                state_d.flag[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ccf = state_q.flag;

endmodule

// File: rtl/adc_seq_scf.sv
module adc_seq_scf
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seq_start,
    input  logic seq_end,
    input  logic res_rd,
    input  logic fast_clear,
    output logic scf
);

    logic        scf_d, scf_q;
    clr_policy_e policy;
    logic        clr;

    always_comb begin
        policy = to_policy(fast_clear);
        clr    = (policy == CLR_BY_RESULT) ? res_rd : seq_start;
        scf_d  = scf_q;
        if (clr) begin
            scf_d = 1'b0;
        end
        if (seq_end) begin
            scf_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scf_q <= 1'b0;
        end else begin
            scf_q <= scf_d;
        end
    end

    assign scf = scf_q;

endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status #(
    parameter int NUM_SLOTS = 8,
    parameter int SHORT_LEN = 4,
    parameter int STATUS_W  = 8,
    localparam int PTR_W = $clog2(NUM_SLOTS),
    localparam int PAD_W = STATUS_W - 1 - PTR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_fast_clear,
    input  logic                 cfg_fifo_mode,
    input  logic                 cfg_scan_mode,
    input  logic                 cfg_long_seq,
    input  logic                 seq_start,
    input  logic                 conv_done,
    input  logic                 res_rd,
    input  logic [PTR_W-1:0]     res_rd_idx,
    input  logic                 stat_rd,
    output logic [STATUS_W-1:0]  status0,
    output logic [NUM_SLOTS-1:0] status1,
    output logic [PTR_W-1:0]     wr_ptr,
    output logic                 seq_active
);

    logic             conv_fire;
    logic [PTR_W-1:0] conv_pos;
    logic             seq_end;
    logic             scf;
    logic [PTR_W-1:0] ptr;

    adc_seq_sequencer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SHORT_LEN (SHORT_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_start (seq_start),
        .conv_done (conv_done),
        .scan_mode (cfg_scan_mode),
        .fifo_mode (cfg_fifo_mode),
        .long_seq  (cfg_long_seq),
        .active    (seq_active),
        .ptr       (ptr),
        .conv_fire (conv_fire),
        .conv_pos  (conv_pos),
        .seq_end   (seq_end)
    );

    adc_seq_ccf #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_ccf (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_start  (seq_start),
        .conv_fire  (conv_fire),
        .conv_pos   (conv_pos),
        .res_rd     (res_rd),
        .res_idx    (res_rd_idx),
        .stat_rd    (stat_rd),
        .fast_clear (cfg_fast_clear),
        .ccf        (status1)
    );

    adc_seq_scf u_scf (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_start  (seq_start),
        .seq_end    (seq_end),
        .res_rd     (res_rd),
        .fast_clear (cfg_fast_clear),
        .scf        (scf)
    );

    assign wr_ptr  = ptr;
    assign status0 = {scf, {PAD_W{1'b0}}, ptr};

endmodule

// File: rtl/adc_seq_status_checker.sv
module adc_seq_status_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int STATUS_W  = 8,
    localparam int PTR_W = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_fast_clear,
    input logic                 cfg_fifo_mode,
    input logic                 seq_start,
    input logic                 conv_done,
    input logic                 res_rd,
    input logic                 stat_rd,
    input logic [STATUS_W-1:0]  status0,
    input logic [NUM_SLOTS-1:0] status1,
    input logic [PTR_W-1:0]     wr_ptr,
    input logic                 seq_active
);

    assert_start_zero_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start && !cfg_fifo_mode |=> wr_ptr == '0);

    assert_fifo_keep_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start && cfg_fifo_mode |=> wr_ptr == $past(wr_ptr));

    assert_start_clear_ccf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> status1 == '0);

    assert_slow_start_scf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start && !cfg_fast_clear |=> !status0[STATUS_W-1]);

    assert_fast_read_scf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fast_clear && res_rd && !conv_done |=> !status0[STATUS_W-1]);

    assert_ccf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && seq_active && !seq_start |=> status1 != '0);

    assert_idle_done_R14: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && !seq_active && !seq_start && !res_rd
        |=> $stable(status0) && $stable(status1));

    assert_quiet_words_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_start && !conv_done && !res_rd && !stat_rd
        |=> $stable(status0) && $stable(status1));

endmodule

bind adc_seq_status adc_seq_status_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .STATUS_W  (STATUS_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_fast_clear (cfg_fast_clear),
    .cfg_fifo_mode  (cfg_fifo_mode),
    .seq_start      (seq_start),
    .conv_done      (conv_done),
    .res_rd         (res_rd),
    .stat_rd        (stat_rd),
    .status0        (status0),
    .status1        (status1),
    .wr_ptr         (wr_ptr),
    .seq_active     (seq_active)
);

// File: tb/adc_seq_status_bench.sv
`timescale 1ns/1ps
module adc_seq_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_fast_clear = 1'b0;
    logic       cfg_fifo_mode = 1'b0;
    logic       cfg_scan_mode = 1'b0;
    logic       cfg_long_seq = 1'b0;
    logic       seq_start = 1'b0;
    logic       conv_done = 1'b0;
    logic       res_rd = 1'b0;
    logic [2:0] res_rd_idx = 3'd0;
    logic       stat_rd = 1'b0;
    logic [7:0] status0;
    logic [7:0] status1;
    logic [2:0] wr_ptr;
    logic       seq_active;

    int    errors = 0;
    int    checks = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    adc_seq_status u_adc_seq_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_fast_clear (cfg_fast_clear),
        .cfg_fifo_mode  (cfg_fifo_mode),
        .cfg_scan_mode  (cfg_scan_mode),
        .cfg_long_seq   (cfg_long_seq),
        .seq_start      (seq_start),
        .conv_done      (conv_done),
        .res_rd         (res_rd),
        .res_rd_idx     (res_rd_idx),
        .stat_rd        (stat_rd),
        .status0        (status0),
        .status1        (status1),
        .wr_ptr         (wr_ptr),
        .seq_active     (seq_active)
    );

    // Behavioural reference model
    bit       m_active;
    int       m_pos;
    int       m_ptr;
    bit       m_scf;
    bit [7:0] m_ccf;
    bit [7:0] m_arm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_pos = 0; m_ptr = 0; m_scf = 0; m_ccf = 0; m_arm = 0;
        end else begin
            int       len;
            bit       acc;
            bit [7:0] old_ccf;
            len = cfg_long_seq ? 8 : 4;
            acc = conv_done && m_active && !seq_start;
            old_ccf = m_ccf;
            if (res_rd) begin
                if (cfg_fast_clear) begin
                    m_scf = 0;
                    m_ccf[res_rd_idx] = 0;
                end else if (m_arm[res_rd_idx]) begin
                    m_ccf[res_rd_idx] = 0;
                end
            end
            if (stat_rd) m_arm = old_ccf;
            if (res_rd) m_arm[res_rd_idx] = 0;
            if (seq_start) begin
                m_active = 1; m_pos = 0; m_ccf = 0; m_arm = 0;
                if (!cfg_fifo_mode) m_ptr = 0;
                if (!cfg_fast_clear) m_scf = 0;
            end else if (acc) begin
                m_ccf[m_pos] = 1;
                m_ptr = (m_ptr + 1) % 8;
                if (m_pos == len - 1) begin
                    m_scf = 1;
                    m_pos = 0;
                    if (cfg_scan_mode) begin
                        if (!cfg_fifo_mode) m_ptr = 0;
                    end else begin
                        m_active = 0;
                    end
                end else begin
                    m_pos = m_pos + 1;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, "model status0", int'(status0), {m_scf, 4'b0000, 3'(m_ptr)});
            check(cur_req, "model status1", int'(status1), int'(m_ccf));
            check(cur_req, "model active", int'(seq_active), int'(m_active));
        end
    end

    task automatic report;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic step(input bit s, input bit c, input bit r, input int idx, input bit st);
        seq_start = s; conv_done = c; res_rd = r; res_rd_idx = 3'(idx); stat_rd = st;
        @(negedge clk);
        seq_start = 0; conv_done = 0; res_rd = 0; stat_rd = 0;
    endtask

    task automatic convs(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 1, 0, 0, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "status0", int'(status0), 0);
        check("R1", "status1", int'(status1), 0);
        check("R1", "wr_ptr", int'(wr_ptr), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "active", int'(seq_active), 0);

        // R3: short sequence, handshake clearing
        cur_req = "R3";
        step(1, 0, 0, 0, 0);
        check("R5", "ptr after start", int'(wr_ptr), 0);
        convs(3);
        check("R2", "status1 mid", int'(status1), 8'h07);
        convs(1);
        check("R3", "status0 end", int'(status0), 8'h84);
        check("R2", "status1 end", int'(status1), 8'h0F);
        check("R3", "active end", int'(seq_active), 0);

        cur_req = "R14";
        step(0, 1, 0, 0, 0);
        check("R14", "idle done status0", int'(status0), 8'h84);
        check("R14", "idle done status1", int'(status1), 8'h0F);

        cur_req = "R10";
        step(0, 0, 1, 1, 0);
        check("R10", "unarmed read", int'(status1), 8'h0F);
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 1, 0);
        check("R10", "armed read", int'(status1), 8'h0D);
        check("R7", "scf after read", int'(status0), 8'h84);

        cur_req = "R7";
        step(1, 0, 0, 0, 0);
        check("R7", "scf after start", int'(status0), 8'h00);
        check("R11", "ccf after start", int'(status1), 8'h00);

        // long sequence with wrap
        cur_req = "R3";
        cfg_long_seq = 1;
        step(1, 0, 0, 0, 0);
        convs(3);
        check("R5", "ptr mid", int'(status0), 8'h03);
        convs(5);
        check("R3", "long end status0", int'(status0), 8'h80);
        check("R2", "long end status1", int'(status1), 8'hFF);

        cur_req = "R9";
        cfg_fast_clear = 1;
        step(0, 0, 1, 5, 0);
        check("R9", "fast read", int'(status1), 8'hDF);
        check("R8", "scf fast read", int'(status0), 8'h00);

        cur_req = "R8";
        cfg_long_seq = 0;
        step(1, 0, 0, 0, 0);
        convs(4);
        check("R8", "scf set", int'(status0), 8'h84);
        step(1, 0, 0, 0, 0);
        check("R8", "start keeps scf", int'(status0), 8'h80);

        cur_req = "R12";
        step(0, 1, 1, 0, 0);
        check("R12", "ccf set wins", int'(status1), 8'h01);
        check("R12", "scf cleared", int'(status0), 8'h01);
        convs(2);
        step(0, 1, 1, 3, 0);
        check("R12", "scf set wins", int'(status0), 8'h84);
        check("R12", "ccf3 set wins", int'(status1), 8'h0F);

        cur_req = "R6";
        cfg_fast_clear = 0;
        cfg_fifo_mode = 1;
        step(1, 0, 0, 0, 0);
        check("R6", "fifo start", int'(status0), 8'h04);
        convs(4);
        check("R6", "fifo wrap", int'(status0), 8'h80);
        step(1, 0, 0, 0, 0);
        convs(1);
        check("R6", "fifo next", int'(status0), 8'h01);

        cur_req = "R4";
        cfg_fifo_mode = 0;
        cfg_scan_mode = 1;
        step(1, 0, 0, 0, 0);
        convs(4);
        check("R4", "scan end", int'(status0), 8'h80);
        check("R4", "scan active", int'(seq_active), 1);
        convs(1);
        check("R4", "scan restart ptr", int'(status0), 8'h81);
        check("R4", "scan flags", int'(status1), 8'h0F);
        cfg_scan_mode = 0;
        convs(3);
        check("R4", "scan stop", int'(seq_active), 0);

        cur_req = "R11";
        step(1, 0, 0, 0, 0);
        convs(1);
        step(1, 1, 0, 0, 0);
        check("R11", "done ignored ccf", int'(status1), 8'h00);
        check("R11", "done ignored ptr", int'(wr_ptr), 0);

        cur_req = "R13";
        for (int i = 0; i < 4000; i++) begin
            if (i % 97 == 0) begin
                cfg_fast_clear = 1'($urandom);
                cfg_fifo_mode  = 1'($urandom);
                cfg_scan_mode  = 1'($urandom);
                cfg_long_seq   = 1'($urandom);
            end
            step(($urandom % 23) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                 int'($urandom % 8), ($urandom % 5) == 0);
        end
        repeat (2) @(negedge clk);
        report();
        $finish;
    end

endmodule